// File: doc/BRIEF.md
# Serial Bus Shift Channel

This block is an 8-bit shift channel for a two-wire serial bus. One wire carries data and is shared: every station only pulls it low, so the level on the wire is the AND of all drivers. The other wire is the serial clock. As master the channel makes the clock itself from the system clock. As slave it follows an external clock. A CPU-side write port loads the shift register, the mode bits, the station's own address and the interrupt and busy controls. The shift register and the interrupt flag are visible at the outputs.

A transfer begins when software writes the shift register, and only if the channel is enabled and the serial clock is idle. As master, the channel also waits until the data wire reads high, which is the addressed slave releasing its busy level. It then runs eight clock pulses and stops by itself with the clock high. Data goes out MSB first: the output bit changes on each falling clock edge and the input bit is sampled on each rising edge. After the eighth bit the interrupt flag is set.

In wakeup mode the channel never pulls the data wire low. The flag is raised only when a received byte equals the own address and a bus release has been seen since the last match. A slave can hold the data wire low as a busy signal after each byte. A request to drop busy takes effect at the next falling edge of the serial clock, and wakeup cannot be switched on while the data wire is low.

Top module: `sbus_shift_chan`

## Requirements
- R1: After reset, `sckOut` is 1, `sdaOe` is 0 and `irq` is 0.
- R2: In master mode (control address 1: bit0 enable, bit1 master), a write to address 0 starts a transfer. The transfer produces exactly 8 falling and 8 rising edges on `sckOut`. Bit 7 is driven first: `sdaOe` = 1 means the bit is 0. The output changes on each falling edge and the wire is sampled on each rising edge. Afterwards `shiftData` holds the sampled byte.
- R3: A write to address 0 while enable is 0 starts nothing, and setting enable later still starts nothing.
- R4: In master mode a transfer does not start while `sdaIn` is 0. The written byte is kept, and the transfer starts once `sdaIn` reads 1.
- R5: After the eighth bit `sckOut` stays at 1 and `irq` becomes 1. Writing address 3 with bit0 = 0 clears `irq`.
- R6: When the byte 0xFF is loaded, `sdaOe` stays 0 for the whole transfer. With wakeup set (control bit2), `sdaOe` stays 0 for any loaded byte.
- R7: With wakeup set, `irq` is raised at the end of a byte only if a release has been seen since the last match and the received byte equals the own address (written at address 2). A release is `sdaIn` rising while `sckIn` is high. A match consumes the release.
- R8: In slave mode with busy enabled (control bit3), `sdaOe` becomes 1 after each byte. After a busy-clear request (address 3, bit1 = 1), `sdaOe` stays 1 until the next falling edge of `sckIn`, then returns to 0.
- R9: A control write that sets wakeup while `sdaIn` is 0 leaves wakeup off.
- R10: In slave mode a write to address 0 starts a transfer only if `sckIn` is 1 at the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | CPU write strobe |
| wrAddr | input | 2 | Write target: 0 shift, 1 control, 2 own address, 3 flag/busy |
| wrData | input | 8 | Write data |
| sckIn | input | 1 | Serial clock level seen on the bus |
| sdaIn | input | 1 | Data wire level seen on the bus |
| sckOut | output | 1 | Serial clock driven as master, high when idle |
| sdaOe | output | 1 | Pulls the data wire low when 1 |
| shiftData | output | 8 | Shift register contents |
| irq | output | 1 | Interrupt request flag |

## Verification
The hardest state to reach from the ports combines three things: the slave is still holding busy, a clear request is pending but its falling clock edge has not come yet, and software tries to switch on wakeup. The bench builds this state by finishing a slave byte with busy enabled and writing the refused wakeup setting while the wire is low. It then issues the clear request and holds the clock high for a while before lowering it. The refusal shows in the next byte, whose zero bits still reach the wire. The address-match gating is driven with release pulses placed between bytes, in the orders match, repeated match, release with mismatch, then match.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef struct packed {
    logic loadSr;
    logic loadAddr;
    logic fall;
    logic rise;
    logic last;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ADDR_SHIFT = 2'd0,
    ADDR_CTRL  = 2'd1,
    ADDR_OWN   = 2'd2,
    ADDR_FLAG  = 2'd3
  } regAddr_t;
endpackage

// File: rtl/sbus_dpath.sv
module sbus_dpath
  import sbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdaIn,
  output logic [DATA_W-1:0] shiftData,
  output logic              dOut,
  output logic              addrMatch
);
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] ownAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      ownAddr  <= '0;
      dOut     <= 1'b1;
    end else begin
      if (stb.loadAddr) ownAddr <= wrData;
      if (stb.loadSr) shiftReg <= wrData;
      else if (stb.rise) shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
      if (stb.last) dOut <= 1'b1;
      else if (stb.fall) dOut <= shiftReg[DATA_W-1];
    end
  end

  assign shiftData = shiftReg;
  assign addrMatch = (shiftReg == ownAddr);
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [3:0]  ctlData,
  input  logic        sckIn,
  input  logic        sdaIn,
  input  logic        addrMatch,
  output ctlStrobes_t stb,
  output logic        sckOut,
  output logic        running,
  output logic        busyDrive,
  output logic        wakeOn,
  output logic        masterOn,
  output logic        irq
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic enOn, busyEn, pending, sckGen, sckQ, sdaQ, finishQ, relFlag, clrPend;
  logic [CW-1:0] bitCnt;
  logic [PW-1:0] phase;
  logic wrSr, wrCtl, wrOwn, wrFlag;
  logic fallS, riseS, halfDone, startM, relDet, wakeHit;

  assign wrSr   = wrEn && (wrAddr == ADDR_SHIFT);
  assign wrCtl  = wrEn && (wrAddr == ADDR_CTRL);
  assign wrOwn  = wrEn && (wrAddr == ADDR_OWN);
  assign wrFlag = wrEn && (wrAddr == ADDR_FLAG);

  assign fallS    = sckQ & ~sckIn;
  assign riseS    = ~sckQ & sckIn;
  assign relDet   = sckIn & sckQ & ~sdaQ & sdaIn;
  assign halfDone = (phase == PW'(HALF_CYC - 1));
  assign startM   = masterOn && pending && !running && sdaIn;
  assign wakeHit  = relFlag && addrMatch;

  generate
    if (HALF_CYC > 0) begin : g_edges
      always_comb begin
        stb          = '0;
        stb.loadSr   = wrSr && !running;
        stb.loadAddr = wrOwn;
        if (masterOn) begin
          stb.fall = startM || (running && halfDone && sckGen);
          stb.rise = running && halfDone && !sckGen;
        end else begin
          stb.fall = running && fallS;
          stb.rise = running && riseS;
        end
        stb.last = stb.rise && (bitCnt == CW'(DATA_W - 1));
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enOn      <= 1'b0;
      masterOn  <= 1'b0;
      wakeOn    <= 1'b0;
      busyEn    <= 1'b0;
      pending   <= 1'b0;
      running   <= 1'b0;
      sckGen    <= 1'b1;
      sckQ      <= 1'b1;
      sdaQ      <= 1'b1;
      finishQ   <= 1'b0;
      relFlag   <= 1'b0;
      clrPend   <= 1'b0;
      busyDrive <= 1'b0;
      irq       <= 1'b0;
      bitCnt    <= '0;
      phase     <= '0;
    end else begin
      sckQ    <= sckIn;
      sdaQ    <= sdaIn;
      finishQ <= stb.last;

      if (wrCtl) begin
        enOn     <= ctlData[0];
        masterOn <= ctlData[1];
        wakeOn   <= ctlData[2] & (wakeOn | sdaIn);
        busyEn   <= ctlData[3];
      end

      if (!enOn) pending <= 1'b0;
      if (stb.loadSr && enOn) begin
        if (masterOn) pending <= 1'b1;
        else if (sckIn) begin
          running <= 1'b1;
          bitCnt  <= '0;
        end
      end

      if (startM) begin
        pending <= 1'b0;
        running <= 1'b1;
        sckGen  <= 1'b0;
        phase   <= '0;
        bitCnt  <= '0;
      end else if (running && masterOn) begin
        phase <= halfDone ? '0 : phase + PW'(1);
        if (halfDone) sckGen <= ~sckGen;
      end

      if (stb.rise) begin
        if (stb.last) running <= 1'b0;
        else bitCnt <= bitCnt + CW'(1);
      end

      if (finishQ && (!wakeOn || wakeHit)) irq <= 1'b1;
      else if (wrFlag && !ctlData[0]) irq <= 1'b0;

      if (relDet) relFlag <= 1'b1;
      else if (finishQ && wakeOn && wakeHit) relFlag <= 1'b0;

      if (finishQ && busyEn && !masterOn) begin
        busyDrive <= 1'b1;
      end else if (busyDrive && clrPend && fallS) begin
        busyDrive <= 1'b0;
        clrPend   <= 1'b0;
      end else if (wrFlag && ctlData[1] && busyDrive) begin
        clrPend <= 1'b1;
      end
    end
  end

  assign sckOut = sckGen;
endmodule

// File: rtl/sbus_shift_chan.sv
module sbus_shift_chan
  import sbus_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sckIn,
  input  logic              sdaIn,
  output logic              sckOut,
  output logic              sdaOe,
  output logic [DATA_W-1:0] shiftData,
  output logic              irq
);
  ctlStrobes_t stb;
  logic dOut, addrMatch, running, busyDrive, wakeOn, masterOn;

  sbus_ctrl #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .ctlData(wrData[3:0]), .sckIn(sckIn), .sdaIn(sdaIn),
    .addrMatch(addrMatch), .stb(stb), .sckOut(sckOut),
    .running(running), .busyDrive(busyDrive), .wakeOn(wakeOn),
    .masterOn(masterOn), .irq(irq)
  );

  sbus_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .sdaIn(sdaIn),
    .shiftData(shiftData), .dOut(dOut), .addrMatch(addrMatch)
  );

  assign sdaOe = (~wakeOn & ~dOut) | busyDrive;
endmodule

// File: rtl/sbus_checker.sv
module sbus_checker (
  input logic clk,
  input logic rstN,
  input logic sckIn,
  input logic sdaIn,
  input logic sckOut,
  input logic sdaOe,
  input logic irq,
  input logic running,
  input logic busyDrive,
  input logic wakeOn,
  input logic masterOn
);
  assert_hold_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    (masterOn && !running && !sdaIn) |=> sckOut);

  assert_irq_clk_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> sckOut);

  assert_wake_hiz_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wakeOn && !busyDrive) |-> !sdaOe);

  assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyDrive) |-> (!$past(sckIn) && $past(sckIn, 2)));

  assert_wake_refused_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeOn) |-> $past(sdaIn));
endmodule

bind sbus_shift_chan sbus_checker u_chk (
  .clk(clk), .rstN(rstN), .sckIn(sckIn), .sdaIn(sdaIn), .sckOut(sckOut),
  .sdaOe(sdaOe), .irq(irq), .running(running), .busyDrive(busyDrive),
  .wakeOn(wakeOn), .masterOn(masterOn)
);

// File: tb/sim_sbus_shift_chan.sv
`timescale 1ns/1ps
module sim_sbus_shift_chan;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic sckIn = 1'b1, slvDrive = 1'b1;
  logic sdaIn, sckOut, sdaOe, irq;
  logic [7:0] shiftData;
  int checks = 0, errors = 0;
  bit finished = 0;

  assign sdaIn = slvDrive & ~sdaOe;
  always #4 clk = ~clk;

  sbus_shift_chan u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sckIn(sckIn), .sdaIn(sdaIn), .sckOut(sckOut), .sdaOe(sdaOe),
    .shiftData(shiftData), .irq(irq)
  );

  function automatic logic [7:0] expRx(input logic [7:0] tx, input logic [7:0] rx, input bit forced);
    return forced ? rx : (tx & rx);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic masterXfer(input bit doWrite, input logic [7:0] tx, input logic [7:0] rx,
                            input int limit, output logic [7:0] seen, output int rises,
                            output bit stayedHigh);
    int falls = 0;
    logic prev = 1'b1;
    rises = 0; seen = '0; stayedHigh = 1;
    if (doWrite) cpuWrite(2'd0, tx);
    for (int t = 0; t < limit && rises < 8; t++) begin
      @(negedge clk);
      if (prev && !sckOut && falls < 8) begin
        seen[7-falls] = ~sdaOe;
        slvDrive = rx[7-falls];
        falls++;
      end
      if (!prev && sckOut) rises++;
      prev = sckOut;
    end
    for (int t = 0; t < 16; t++) begin
      @(negedge clk);
      if (!sckOut) stayedHigh = 0;
    end
    slvDrive = 1'b1;
  endtask

  task automatic slaveXfer(input logic [7:0] rx, output logic [7:0] seen);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) sckIn = 1'b0;
      repeat (3) @(negedge clk);
      seen[i] = ~sdaOe;
      slvDrive = rx[i];
      @(negedge clk) sckIn = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic busRelease();
    @(negedge clk) slvDrive = 1'b0;
    repeat (2) @(negedge clk);
    slvDrive = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish();
  end

  initial begin
    logic [7:0] tx, rx, seen;
    int rises;
    bit high;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 sckOut", sckOut, 1);
    chk("R1 sdaOe", sdaOe, 0);
    chk("R1 irq", irq, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3: write while disabled, enable afterwards
    cpuWrite(2'd1, 8'h02);
    cpuWrite(2'd0, 8'hA5);
    cpuWrite(2'd1, 8'h03);
    masterXfer(0, 8'h00, 8'hFF, 120, seen, rises, high);
    chk("R3 no clock", rises, 0);
    chk("R3 no irq", irq, 0);

    // R6 directed: all ones
    masterXfer(1, 8'hFF, 8'h3C, 2000, seen, rises, high);
    chk("R6 hi-z ones", seen, 8'hFF);
    chk("R6 rx", shiftData, 8'h3C);
    cpuWrite(2'd3, 8'h00);

    // R2/R5 random master traffic
    for (int n = 0; n < 20; n++) begin
      tx = 8'($urandom); rx = 8'($urandom);
      if (n == 0) begin tx = 8'h80; rx = 8'h01; end
      masterXfer(1, tx, rx, 2000, seen, rises, high);
      chk("R2 rises", rises, 8);
      chk("R2 tx bits", seen, tx);
      chk("R2 rx byte", shiftData, expRx(tx, rx, 0));
      chk("R5 clock idle high", high, 1);
      chk("R5 irq set", irq, 1);
      cpuWrite(2'd3, 8'h00);
      chk("R5 irq clear", irq, 0);
    end

    // R4: held while slave busy
    slvDrive = 1'b0;
    cpuWrite(2'd0, 8'h6D);
    masterXfer(0, 8'h00, 8'h00, 100, seen, rises, high);
    chk("R4 held", rises, 0);
    slvDrive = 1'b1;
    masterXfer(0, 8'h00, 8'hFF, 2000, seen, rises, high);
    chk("R4 started", rises, 8);
    chk("R4 data kept", seen, 8'h6D);
    cpuWrite(2'd3, 8'h00);

    // R10: slave, clock low at write
    cpuWrite(2'd1, 8'h01);
    @(negedge clk) sckIn = 1'b0;
    cpuWrite(2'd0, 8'h5A);
    slaveXfer(8'h00, seen);
    chk("R10 no irq", irq, 0);
    chk("R10 not shifted", shiftData, 8'h5A);
    for (int n = 0; n < 10; n++) begin
      tx = 8'($urandom); rx = 8'($urandom);
      cpuWrite(2'd0, tx);
      slaveXfer(rx, seen);
      chk("R10 slave tx", seen, tx);
      chk("R10 slave rx", shiftData, expRx(tx, rx, 0));
      chk("R5 slave irq", irq, 1);
      cpuWrite(2'd3, 8'h00);
    end

    // R8/R9: busy handling
    cpuWrite(2'd1, 8'h09);
    cpuWrite(2'd0, 8'hC3);
    slaveXfer(8'hFF, seen);
    chk("R8 busy on", sdaOe, 1);
    cpuWrite(2'd1, 8'h05);
    cpuWrite(2'd3, 8'h03);
    repeat (10) @(negedge clk);
    chk("R8 busy held", sdaOe, 1);
    @(negedge clk) sckIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 busy released", sdaOe, 0);
    @(negedge clk) sckIn = 1'b1;
    repeat (2) @(negedge clk);
    cpuWrite(2'd3, 8'h00);
    cpuWrite(2'd0, 8'h00);
    slaveXfer(8'hFF, seen);
    chk("R9 wake refused", seen, 8'h00);
    chk("R9 rx", shiftData, 8'h00);
    cpuWrite(2'd3, 8'h00);

    // R7: wakeup address match
    cpuWrite(2'd2, 8'h5B);
    cpuWrite(2'd1, 8'h05);
    busRelease();
    cpuWrite(2'd0, 8'h00);
    slaveXfer(8'h5B, seen);
    chk("R6 wake hi-z", seen, 8'hFF);
    chk("R7 match irq", irq, 1);
    cpuWrite(2'd3, 8'h00);
    cpuWrite(2'd0, 8'h12);
    slaveXfer(8'h5B, seen);
    chk("R7 no release", irq, 0);
    busRelease();
    cpuWrite(2'd0, 8'h00);
    slaveXfer(8'h37, seen);
    chk("R7 mismatch", irq, 0);
    chk("R7 rx", shiftData, 8'h37);
    cpuWrite(2'd0, 8'h00);
    slaveXfer(8'h5B, seen);
    chk("R7 release kept", irq, 1);

    finish();
  end
endmodule